// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block arbitrates a shared, PCI-style bus among four agents. Each agent has an active-low request line and receives an active-low grant line. A granted agent owns the bus for exactly one transaction. The arbiter watches the bus frame and ready strobes to find where a transaction begins and ends. When nobody is asking for the bus, the grant stays parked on the agent that held it last.

Agents are split into a fast ring and a slow ring. A one-bit-per-agent level register sets which ring each agent belongs to, and the top agent is always in the slow ring. The fast ring is scanned in index order. The whole slow ring takes up a single slot in that scan, placed after the highest index. Each time the scan reaches that slot, the slow ring moves forward by one agent. As a result, all slow agents together get the same share of the bus as one fast agent.

Whenever ownership moves from one agent to another, one clock with no grant asserted is inserted between the old and new grant.

Top module: `tieredRrArbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `gntN` is 4'b1110 (agent 0 parked) and `cfgLevel` is 4'b1111 (every agent in the slow ring).
- R2: At most one bit of `gntN` is low at any time. When ownership changes, exactly one cycle with `gntN` = 4'b1111 separates the old grant from the new one. An all-high cycle is always followed by a grant.
- R3: When `cfgWrEn` is sampled high, `cfgWrData` is loaded into `cfgLevel` on that edge. Bit i = 1 puts agent i in the slow ring and 0 puts it in the fast ring. Bit 3 always reads 1, so writing 0 to it has no effect.
- R4: If no request is active, the grant stays on the last owner for as long as the requests stay inactive.
- R5: The arbiter may be parked on an owner that has not started a transaction and is not requesting. If another agent requests while the bus is idle (`frameN` and `irdyN` both high), the next cycle has no grant, and the cycle after that grants the winner.
- R6: The grant does not change while `frameN` or `irdyN` is low. Once the owner has driven `frameN` low, the first idle cycle triggers a single arbitration. If that arbitration picks a different agent, the handover follows R2.
- R7: Arbitration scans five ring positions in the cyclic order agent 0, 1, 2, 3, then the slow slot. The scan starts just after the position served last. Position i is eligible when agent i is in the fast ring and requesting. After reset, the last position served is the slow slot.
- R8: The slow slot is eligible when any slow agent requests. Taking the slot grants the first requesting slow agent in cyclic index order after the slow agent served last (agent 3 after reset). With every agent requesting under levels 4'b1100, agents 0 and 1 each get about as many transactions as agents 2 and 3 combined, and agents 2 and 3 share equally.
- R9: With no fast agent requesting, the slow agents are served in rotation. With every agent in the slow ring and all requesting, all four get equal shares.
- R10: If the arbitration at the end of a transaction picks the current owner again, its grant stays asserted with no gap.
- R11: An owner that is still requesting but has not started a transaction keeps the grant, even while other agents request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqN | input | 4 | Per-agent bus request, active low |
| frameN | input | 1 | Bus frame strobe, active low |
| irdyN | input | 1 | Bus initiator-ready strobe, active low |
| cfgWrEn | input | 1 | Level register write enable |
| cfgWrData | input | 4 | Level register write data, 1 = slow ring |
| gntN | output | 4 | Per-agent bus grant, active low |
| cfgLevel | output | 4 | Current level register contents |

## Verification
The hardest state to reach from the ports is a long run in which every agent keeps requesting and real transactions keep ending, so that the slow slot recurs many times. Only such a run shows the slow ring advancing once per fast-ring turn. The bench therefore includes an automatic bus master. Whenever the granted agent is requesting and the bus is idle, it starts a legal transaction of one to three data phases. This lets long contention windows run, and the bench counts transactions per agent for each level setting. Directed sequences cover the remaining corners: leaving the parked state, an owner that holds its grant without starting, and the same owner winning again. A behavioural reference model, compared on every clock, covers random request patterns and level writes.

// File: rtl/tieredRrPkg.sv
package tieredRrPkg;

  typedef struct packed {
    logic commit;     // record the current winner and move the ring pointers
    logic takeOwner;  // make the recorded winner the owner
    logic gntOn;      // drive the owner's grant
  } arbStrobes_t;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_GAP  = 1'b1
  } arbState_t;

endpackage

// File: rtl/tieredRrPick.sv
module tieredRrPick
  import tieredRrPkg::*;
#(
  parameter int NumAgents = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NumAgents-1:0] reqN,
  input  logic                 cfgWrEn,
  input  logic [NumAgents-1:0] cfgWrData,
  input  arbStrobes_t          stb,
  output logic [NumAgents-1:0] gntN,
  output logic [NumAgents-1:0] cfgLevel,
  output logic                 anyWin,
  output logic                 winIsOwner,
  output logic                 ownerReq,
  output logic                 otherReq
);

  localparam int IdxW = (NumAgents > 1) ? $clog2(NumAgents) : 1;
  localparam int NumPos = NumAgents + 1;
  localparam int PosW = $clog2(NumPos);
  localparam logic [NumAgents-1:0] FixedSlow = {1'b1, {(NumAgents-1){1'b0}}};

  logic [NumAgents-1:0] levelQ;
  logic [PosW-1:0]      posQ;
  logic [IdxW-1:0]      lastSlowQ;
  logic [IdxW-1:0]      ownerQ;
  logic [IdxW-1:0]      pendQ;

  logic [NumAgents-1:0] reqVec, fastReq, slowReq, ownerHot;
  logic                 slowFound, slotTaken;
  logic [IdxW-1:0]      slowIdx, winIdx;
  logic [PosW-1:0]      winPos;
  int                   cand;

  assign reqVec  = ~reqN;
  assign fastReq = reqVec & ~levelQ;
  assign slowReq = reqVec & levelQ;

  always_comb begin
    slowFound = 1'b0;
    slowIdx   = '0;
    cand      = 0;
    for (int k = 1; k <= NumAgents; k++) begin
      cand = (int'(lastSlowQ) + k) % NumAgents;
      if (!slowFound && slowReq[cand]) begin
        slowFound = 1'b1;
        slowIdx   = IdxW'(cand);
      end
    end
  end

  logic winFound;
  int   ringPos;
  always_comb begin
    winFound  = 1'b0;
    slotTaken = 1'b0;
    winPos    = '0;
    ringPos   = 0;
    for (int k = 1; k <= NumPos; k++) begin
      ringPos = (int'(posQ) + k) % NumPos;
      if (!winFound) begin
        if (ringPos == NumAgents) begin
          if (slowFound) begin
            winFound  = 1'b1;
            slotTaken = 1'b1;
            winPos    = PosW'(ringPos);
          end
        end else if (fastReq[ringPos]) begin
          winFound = 1'b1;
          winPos   = PosW'(ringPos);
        end
      end
    end
    winIdx = slotTaken ? slowIdx : IdxW'(winPos);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ    <= '1;
      posQ      <= PosW'(NumAgents);
      lastSlowQ <= IdxW'(NumAgents - 1);
      ownerQ    <= '0;
      pendQ     <= '0;
    end else begin
      if (cfgWrEn) levelQ <= cfgWrData | FixedSlow;
      if (stb.commit) begin
        posQ  <= winPos;
        pendQ <= winIdx;
        if (slotTaken) lastSlowQ <= slowIdx;
      end
      if (stb.takeOwner) ownerQ <= pendQ;
    end
  end

  for (genvar g = 0; g < NumAgents; g++) begin : gGrant
    assign ownerHot[g] = (ownerQ == IdxW'(g));
    assign gntN[g]     = !(stb.gntOn && ownerHot[g]);
  end

  assign cfgLevel   = levelQ;
  assign anyWin     = winFound;
  assign winIsOwner = (winIdx == ownerQ);
  assign ownerReq   = |(reqVec & ownerHot);
  assign otherReq   = |(reqVec & ~ownerHot);

endmodule

// File: rtl/tieredRrCtrl.sv
module tieredRrCtrl
  import tieredRrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        anyWin,
  input  logic        winIsOwner,
  input  logic        ownerReq,
  input  logic        otherReq,
  output arbStrobes_t stb
);

  arbState_t stateQ, stateD;
  logic      startedQ, startedD;
  logic      busIdle, rearb;

  assign busIdle = frameN && irdyN;
  assign rearb   = (stateQ == ST_HOLD) && busIdle &&
                   (startedQ || (!ownerReq && otherReq));

  always_comb begin
    stb      = '0;
    stateD   = stateQ;
    startedD = startedQ;
    unique case (stateQ)
      ST_HOLD: begin
        stb.gntOn = 1'b1;
        if (rearb) begin
          startedD   = 1'b0;
          stb.commit = anyWin;
          if (anyWin && !winIsOwner) stateD = ST_GAP;
        end else if (!frameN) begin
          startedD = 1'b1;
        end
      end
      ST_GAP: begin
        stb.takeOwner = 1'b1;
        startedD      = 1'b0;
        stateD        = ST_HOLD;
      end
      default: stateD = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_HOLD;
      startedQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      startedQ <= startedD;
    end
  end

endmodule

// File: rtl/tieredRrArbiter.sv
module tieredRrArbiter
  import tieredRrPkg::*;
#(
  parameter int NumAgents = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NumAgents-1:0] reqN,
  input  logic                 frameN,
  input  logic                 irdyN,
  input  logic                 cfgWrEn,
  input  logic [NumAgents-1:0] cfgWrData,
  output logic [NumAgents-1:0] gntN,
  output logic [NumAgents-1:0] cfgLevel
);

  arbStrobes_t stb;
  logic anyWin, winIsOwner, ownerReq, otherReq;

  tieredRrCtrl uCtrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .anyWin(anyWin), .winIsOwner(winIsOwner),
    .ownerReq(ownerReq), .otherReq(otherReq), .stb(stb)
  );

  tieredRrPick #(.NumAgents(NumAgents)) uPick (
    .clk(clk), .rstN(rstN), .reqN(reqN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .stb(stb),
    .gntN(gntN), .cfgLevel(cfgLevel), .anyWin(anyWin),
    .winIsOwner(winIsOwner), .ownerReq(ownerReq), .otherReq(otherReq)
  );

endmodule

// File: rtl/tieredRrChecker.sv
module tieredRrChecker #(
  parameter int NumAgents = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 frameN,
  input logic                 irdyN,
  input logic [NumAgents-1:0] gntN,
  input logic [NumAgents-1:0] cfgLevel
);

  // R2: never two grants at once
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~gntN));

  // R2: a different owner is only reached through an all-high cycle
  a_r2_no_direct_switch: assert property (@(posedge clk) disable iff (!rstN)
    (gntN != '1 && $past(gntN) != '1) |-> (gntN == $past(gntN)));

  // R2: the gap lasts a single cycle
  a_r2_gap_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (gntN == '1) |=> (gntN != '1));

  // R3: top agent stays in the slow ring
  a_r3_top_agent_slow: assert property (@(posedge clk) disable iff (!rstN)
    cfgLevel[NumAgents-1]);

  // R6: grant frozen while the bus is busy
  a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    ((!frameN || !irdyN) && gntN != '1) |=> $stable(gntN));

endmodule

bind tieredRrArbiter tieredRrChecker #(.NumAgents(NumAgents)) uChk (
  .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
  .gntN(gntN), .cfgLevel(cfgLevel)
);

// File: tb/tb_tieredRrArbiter.sv
`timescale 1ns/1ps
module tb_tieredRrArbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] reqN = 4'hF;
  logic frameN = 1'b1;
  logic irdyN = 1'b1;
  logic cfgWrEn = 1'b0;
  logic [3:0] cfgWrData = 4'h0;
  logic [3:0] gntN;
  logic [3:0] cfgLevel;

  always #4 clk = ~clk;  // 125 MHz

  tieredRrArbiter dut (
    .clk(clk), .rstN(rstN), .reqN(reqN), .frameN(frameN), .irdyN(irdyN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .gntN(gntN), .cfgLevel(cfgLevel)
  );

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic checkTrue(input string tag, input bit ok, input int a, input int b);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, b);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mOwner, mPend, mPos, mLastSlow;
  bit mGap, mStarted;
  bit [3:0] mLevel;
  bit [3:0] mReq;
  int ring[$];
  int mWin;
  bit mSlot, mFound;

  function automatic int slowPick(input bit [3:0] r, input bit [3:0] lv, input int last);
    for (int step = 1; step <= 4; step++) begin
      int a;
      a = (last + step) % 4;
      if (r[a] && lv[a]) return a;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOwner = 0; mPend = 0; mPos = 4; mLastSlow = 3;
      mGap = 0; mStarted = 0; mLevel = 4'hF;
    end else begin
      mReq = ~reqN;
      if (mGap) begin
        mOwner = mPend; mGap = 0; mStarted = 0;
      end else if (frameN && irdyN &&
                   (mStarted || (!mReq[mOwner] && (mReq & ~(4'b1 << mOwner)) != 0))) begin
        mStarted = 0;
        ring.delete();
        for (int step = 1; step <= 5; step++) ring.push_back((mPos + step) % 5);
        mFound = 0; mSlot = 0; mWin = -1;
        while (ring.size() > 0 && !mFound) begin
          int p;
          p = ring.pop_front();
          if (p == 4) begin
            if (slowPick(mReq, mLevel, mLastSlow) >= 0) begin
              mFound = 1; mSlot = 1; mWin = slowPick(mReq, mLevel, mLastSlow); mPos = 4;
            end
          end else if (mReq[p] && !mLevel[p]) begin
            mFound = 1; mWin = p; mPos = p;
          end
        end
        if (mFound) begin
          if (mSlot) mLastSlow = mWin;
          mPend = mWin;
          if (mWin != mOwner) mGap = 1;
        end
      end else if (!frameN) begin
        mStarted = 1;
      end
      if (cfgWrEn) mLevel = cfgWrData | 4'b1000;
    end
  end

  // ---------------- bus master helper ----------------
  bit autoBus = 0;
  int busRem = 0;
  int txnCnt[4];

  function automatic int grantedAgent();
    for (int a = 0; a < 4; a++) if (!gntN[a]) return a;
    return -1;
  endfunction

  task automatic busTick();
    int g;
    g = grantedAgent();
    if (autoBus && busRem == 0 && frameN && irdyN && g >= 0 && !reqN[g]) begin
      busRem = 2 + int'($urandom % 3);
      txnCnt[g]++;
    end
    if (busRem > 0) begin
      frameN = (busRem > 1) ? 1'b0 : 1'b1;
      irdyN = 1'b0;
      busRem--;
    end else if (autoBus) begin
      frameN = 1'b1;
      irdyN = 1'b1;
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rstN) check("R7 model grant", gntN, mGap ? 4'hF : ~(4'b1 << mOwner));
    if (rstN) check("R3 model level", cfgLevel, mLevel);
    busTick();
  endtask

  task automatic stepN(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic fairRun(input logic [3:0] lv, input int cycles);
    cfgWrEn = 1'b1; cfgWrData = lv;
    step();
    cfgWrEn = 1'b0;
    reqN = 4'h0;
    autoBus = 1;
    stepN(20);
    for (int a = 0; a < 4; a++) txnCnt[a] = 0;
    stepN(cycles);
  endtask

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset grant", gntN, 4'b1110);
    check("R1 reset level", cfgLevel, 4'b1111);
    rstN = 1'b1;
    step();
    check("R1 first cycle grant", gntN, 4'b1110);

    stepN(5);
    check("R4 parked on agent0", gntN, 4'b1110);

    cfgWrEn = 1'b1; cfgWrData = 4'b0000;
    step();
    cfgWrEn = 1'b0;
    step();
    check("R3 top bit stays 1", cfgLevel, 4'b1000);

    reqN = 4'b1011;
    step();
    check("R5 gap on leave park", gntN, 4'b1111);
    step();
    check("R5 grant agent2", gntN, 4'b1011);

    reqN = 4'b1001;
    stepN(3);
    check("R11 owner keeps unstarted grant", gntN, 4'b1011);

    frameN = 0; irdyN = 0; step();
    check("R6 held in data phase", gntN, 4'b1011);
    step();
    frameN = 1; irdyN = 0; step();
    check("R6 held in last phase", gntN, 4'b1011);
    frameN = 1; irdyN = 1; step();
    check("R6 gap after end", gntN, 4'b1111);
    step();
    check("R6 R7 next agent1", gntN, 4'b1101);

    reqN = 4'b1101;
    frameN = 0; irdyN = 0; step();
    frameN = 1; irdyN = 0; step();
    frameN = 1; irdyN = 1; step();
    check("R10 same owner no gap", gntN, 4'b1101);
    step();
    check("R10 same owner still", gntN, 4'b1101);

    reqN = 4'hF;
    stepN(4);
    check("R4 parked on last owner", gntN, 4'b1101);

    fairRun(4'b1100, 600);
    checkTrue("R8 agent0 vs agent1", absd(txnCnt[0], txnCnt[1]) <= 2, txnCnt[0], txnCnt[1]);
    checkTrue("R8 agent0 vs slow ring", absd(txnCnt[0], txnCnt[2] + txnCnt[3]) <= 2,
              txnCnt[0], txnCnt[2] + txnCnt[3]);
    checkTrue("R8 agent2 vs agent3", absd(txnCnt[2], txnCnt[3]) <= 1, txnCnt[2], txnCnt[3]);
    checkTrue("R8 slow ring served", txnCnt[2] > 5, txnCnt[2], 6);

    fairRun(4'b1111, 600);
    for (int a = 1; a < 4; a++)
      checkTrue("R9 equal slow shares", absd(txnCnt[0], txnCnt[a]) <= 1, txnCnt[a], txnCnt[0]);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 4 == 0) reqN = 4'($urandom);
      cfgWrEn = ($urandom % 50 == 0);
      cfgWrData = 4'($urandom);
      step();
    end
    cfgWrEn = 1'b0;
    autoBus = 0;
    while (busRem > 0) step();
    frameN = 1; irdyN = 1;
    reqN = 4'hF;
    stepN(6);
    checkTrue("R4 random end parked", gntN != 4'hF && $countones(~gntN) == 1, int'(gntN), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule